// File: doc/BRIEF.md
# SONET Frame Aligning Deserializer

This block turns a serial receive bit stream into parallel words of eight bits, or of four bits on a narrow bus. A bit is taken on each clock where the bit enable is high. The block keeps the last 48 received bits and compares them with the SONET/SDH framing pattern: three 0xF6 bytes followed by three 0x28 bytes. When it finds the pattern, it raises a frame pulse.

The frame search input picks how a pattern match is handled. When search is on, a match at any bit offset is reported, and the word boundary moves to the last bit of the pattern. When search is off, the word boundary stays fixed. In that case a match is reported only if its last bit is also the last bit of a word.

A single clock with a bit enable stands in for the separate bit clock and word clock. The word strobe marks the cycle in which a new word is on the output.

Top module: `sonet_frame_deser`

## Requirements
- R1: A synchronous active-low reset clears the bit history and the bit position count. It also sets the word output to 0x00 and the word strobe and frame pulse to 0. After reset, the first bit that is received is the first bit of a word.
- R2: In 8-bit mode (`narrow_mode`=0), every 8th accepted bit completes a word. On the clock after the bit enable of that 8th bit, `word_out` holds the word and `word_stb` is 1. The first bit of the word is in bit 7 and the last bit is in bit 0.
- R3: In 4-bit mode (`narrow_mode`=1), every 4th accepted bit completes a word. The first bit of the word is in bit 7 and the last bit is in bit 4. Bits 3 to 0 are 0.
- R4: On a clock where `bit_en` is 0, no bit is taken. On the next clock, `word_out` does not change and `word_stb` and `frame_pulse` are 0.
- R5: With `search_en`=1, a bit that completes the 48-bit pattern 0xF6F6F6282828 ends a word at once, whatever the count. That word is the 8 most recent bits (0x28), or in 4-bit mode the 4 most recent bits (0x80). It has `frame_pulse`=1.
- R6: After a realignment, the bit count starts again. The next word is complete after 8 more accepted bits, or 4 more in 4-bit mode.
- R7: With `search_en`=0, `frame_pulse` is 1 only when the pattern ends on the last bit of a word. A match at any other offset gives no pulse and does not move the word boundary.
- R8: `frame_pulse` is 1 only in a cycle where `word_stb` is 1, and never in two cycles one after the other. The word and the pulse come from the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | The bit on `bit_in` is taken on this clock |
| bit_in | input | 1 | Serial receive data |
| search_en | input | 1 | 1: a pattern match moves the word boundary; 0: the word boundary is fixed |
| narrow_mode | input | 1 | 1: 4-bit words; 0: 8-bit words |
| word_out | output | 8 | Parallel word, first received bit in bit 7 |
| word_stb | output | 1 | One-cycle strobe: a new word is on `word_out` |
| frame_pulse | output | 1 | One-cycle pulse: this word holds the last bit of the framing pattern |

## Verification
A pattern match and a regular word boundary can fall on the same bit. In that case one word comes out, with the pulse. No second, shorter word may follow.

The bench brings about this case in two ways:
- It sends the pattern aligned to the boundary with search off. The pulse must appear with the sixth pattern byte.
- It sends the pattern three bits off the boundary, once with search off and once with search on.

With search off, no pulse is allowed. With search on, the realigned word must come out right away. The next word must then follow exactly one word length later.

A scoreboard model built from the requirements predicts each word and each pulse.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   localparam int unsigned PAT_W = 48;
   localparam logic [PAT_W-1:0] FRAME_PATTERN = 48'hF6F6F6282828;
endpackage

// File: rtl/sfd_history.sv
module sfd_history #(
   parameter int unsigned HIST_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [HIST_W-1:0] hist_nxt
);
   logic [HIST_W-1:0] hist_q;

   // Newest bit enters at bit 0, so the oldest bit sits highest.
   assign hist_nxt = {hist_q[HIST_W-2:0], din};

   always_ff @(posedge clk) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= hist_nxt;
   end
endmodule

// File: rtl/sfd_matcher.sv
module sfd_matcher #(
   parameter int unsigned HIST_W = 48,
   parameter logic [HIST_W-1:0] PATTERN = '0,
   parameter int unsigned SLICE_W = 8
) (
   input  logic [HIST_W-1:0] window,
   output logic              hit
);
   localparam int unsigned N_SLICE = HIST_W / SLICE_W;

   if (N_SLICE * SLICE_W != HIST_W) begin : g_bad_slice
      $error("sfd_matcher: HIST_W must be a multiple of SLICE_W");
   end

   logic [N_SLICE-1:0] slice_eq;

   // Compare one slice at a time so the reduction tree stays shallow.
   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      assign slice_eq[s] =
         (window[s*SLICE_W +: SLICE_W] == PATTERN[s*SLICE_W +: SLICE_W]);
   end

   assign hit = &slice_eq;
endmodule

// File: rtl/sfd_packer.sv
module sfd_packer #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              narrow_mode,
   input  logic              search_en,
   input  logic              hit,
   input  logic [WORD_W-1:0] recent,
   output logic [WORD_W-1:0] word_out,
   output logic              word_stb,
   output logic              frame_pulse
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_pos;
   logic              at_edge;
   logic              realign;
   logic              emit;
   logic [WORD_W-1:0] packed_word;

   assign last_pos = narrow_mode ? LAST_NARROW : LAST_WIDE;
   assign at_edge  = (cnt_q >= last_pos);
   assign realign  = search_en & hit;
   assign emit     = bit_en & (realign | at_edge);

   // Place the latest bits MSB-first; in narrow mode the unused low bits are zero.
   for (genvar i = 0; i < WORD_W; i++) begin : g_pack
      if (i >= WORD_W - NARROW_W) begin : g_upper
         assign packed_word[i] = narrow_mode ? recent[i - (WORD_W - NARROW_W)]
                                             : recent[i];
      end else begin : g_lower
         assign packed_word[i] = narrow_mode ? 1'b0 : recent[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         word_out    <= '0;
         word_stb    <= 1'b0;
         frame_pulse <= 1'b0;
      end else begin
         word_stb    <= emit;
         frame_pulse <= emit & hit;
         if (emit) begin
            word_out <= packed_word;
            cnt_q    <= '0;
         end else if (bit_en) begin
            cnt_q    <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sonet_frame_deser.sv
module sonet_frame_deser #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              search_en,
   input  logic              narrow_mode,
   output logic [WORD_W-1:0] word_out,
   output logic              word_stb,
   output logic              frame_pulse
);
   import sfd_pkg::*;

   if (NARROW_W == 0 || NARROW_W > WORD_W) begin : g_bad_narrow
      $error("sonet_frame_deser: NARROW_W must be in 1..WORD_W");
   end
   if (WORD_W > PAT_W) begin : g_bad_word
      $error("sonet_frame_deser: WORD_W must not exceed the pattern width");
   end

   logic [PAT_W-1:0] hist_nxt;
   logic             hit;

   sfd_history #(.HIST_W(PAT_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_en),
      .din      (bit_in),
      .hist_nxt (hist_nxt)
   );

   sfd_matcher #(.HIST_W(PAT_W), .PATTERN(FRAME_PATTERN), .SLICE_W(8)) u_match (
      .window (hist_nxt),
      .hit    (hit)
   );

   sfd_packer #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .narrow_mode (narrow_mode),
      .search_en   (search_en),
      .hit         (hit),
      .recent      (hist_nxt[WORD_W-1:0]),
      .word_out    (word_out),
      .word_stb    (word_stb),
      .frame_pulse (frame_pulse)
   );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned NARROW_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              narrow_mode,
   input logic [WORD_W-1:0] word_out,
   input logic              word_stb,
   input logic              frame_pulse
);
   // Counts accepted bits since the last strobe cycle, without looking at the design's state.
   int unsigned bits_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)        bits_seen <= 0;
      else if (word_stb) bits_seen <= bit_en ? 1 : 0;
      else if (bit_en)   bits_seen <= bits_seen + 1;
   end

   a_r8_pulse_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> word_stb);

   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> !frame_pulse);

   a_r4_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> !word_stb);

   a_r4_idle_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(word_out));

   a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && narrow_mode) |-> (word_out[WORD_W-NARROW_W-1:0] == '0));

   a_r2_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && !frame_pulse) |->
         (bits_seen == (narrow_mode ? NARROW_W : WORD_W)));
endmodule

bind sonet_frame_deser sfd_checker #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .narrow_mode (narrow_mode),
   .word_out    (word_out),
   .word_stb    (word_stb),
   .frame_pulse (frame_pulse)
);

// File: tb/sonet_frame_deser_bench.sv
`timescale 1ns/1ps
module sonet_frame_deser_bench;
   localparam logic [47:0] PAT = 48'hF6F6F6282828;

   typedef struct {
      logic [7:0] word;
      logic       fp;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic       search_en = 1'b0;
   logic       narrow_mode = 1'b0;
   logic [7:0] word_out;
   logic       word_stb;
   logic       frame_pulse;

   int   n_checks = 0;
   int   n_fail = 0;
   int   cycles = 0;
   exp_t sb[$];

   logic [47:0] m_hist;
   int          m_cnt;
   string       cur_tag;

   always #5 clk = ~clk;

   sonet_frame_deser u_sonet_frame_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .bit_in      (bit_in),
      .search_en   (search_en),
      .narrow_mode (narrow_mode),
      .word_out    (word_out),
      .word_stb    (word_stb),
      .frame_pulse (frame_pulse)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: compares every strobed word with the oldest expected item.
   always @(negedge clk) begin
      if (rst_n) begin
         if (word_stb) begin
            if (sb.size() == 0) begin
               check("R4 unexpected strobe", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " word"}, {24'd0, word_out}, {24'd0, e.word});
               check({e.tag, " frame pulse"}, {31'd0, frame_pulse}, {31'd0, e.fp});
            end
         end else if (frame_pulse) begin
            check("R8 pulse without strobe", 32'd1, 32'd0);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      bit_en = 1'b0;
      repeat (2) @(negedge clk);
      m_hist = '0;
      m_cnt  = 0;
      sb.delete();
      rst_n  = 1'b1;
   endtask

   // Driver: applies one bit and pushes the expected word if one completes.
   task automatic send_bit(input logic b);
      logic [47:0] nxt;
      logic        match;
      int          wl;
      exp_t        e;
      nxt   = {m_hist[46:0], b};
      match = (nxt == PAT);
      wl    = narrow_mode ? 4 : 8;
      m_hist = nxt;
      if ((search_en && match) || m_cnt == wl - 1) begin
         e.word = narrow_mode ? {nxt[3:0], 4'h0} : nxt[7:0];
         e.fp   = match;
         e.tag  = cur_tag;
         sb.push_back(e);
         m_cnt = 0;
      end else begin
         m_cnt++;
      end
      bit_en = 1'b1;
      bit_in = b;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic send_bits(input logic [63:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      check({cur_tag, " queue empty"}, sb.size(), 0);
   endtask

   initial begin
      do_reset();
      // R1: outputs after reset
      check("R1 word after reset", {24'd0, word_out}, 0);
      check("R1 strobe after reset", {31'd0, word_stb}, 0);
      check("R1 pulse after reset", {31'd0, frame_pulse}, 0);

      cur_tag = "R2";
      send_bits(64'hA5, 8);
      send_bits(64'h3C, 8);
      drain();

      // R4: idle clocks keep the word and give no strobe
      cur_tag = "R4";
      repeat (5) @(negedge clk);
      check("R4 word held while idle", {24'd0, word_out}, 32'h3C);
      check("R4 no strobe while idle", {31'd0, word_stb}, 0);
      send_bit(1'b1);
      repeat (3) @(negedge clk);
      send_bits(64'h5A >> 1, 7);
      drain();

      // R7: aligned pattern with search off gives a pulse on the last byte
      cur_tag = "R7 aligned";
      send_bits(64'hF6F6F6282828, 48);
      drain();

      // R7: misaligned pattern with search off gives no pulse and keeps the boundary
      cur_tag = "R7 misaligned";
      send_bits(64'h5, 3);
      send_bits(64'hF6F6F6282828, 48);
      send_bits(64'h1B, 5);
      drain();

      // R5/R6: misaligned pattern with search on realigns
      search_en = 1'b1;
      cur_tag = "R5 realign";
      send_bits(64'h2, 3);
      send_bits(64'hF6F6F6282828, 48);
      check("R5 realigned queue tail", {24'd0, sb[sb.size()-1].word}, 32'h28);
      cur_tag = "R6 after realign";
      send_bits(64'h81, 8);
      send_bits(64'hC3, 8);
      drain();

      // R1: reset mid-word restarts the boundary
      send_bits(64'h5, 5);
      do_reset();
      search_en = 1'b0;
      cur_tag = "R1 restart";
      send_bits(64'h96, 8);
      drain();

      // R3: narrow bus
      @(negedge clk);
      narrow_mode = 1'b1;
      do_reset();
      cur_tag = "R3";
      send_bits(64'h9E7, 12);
      drain();
      search_en = 1'b1;
      cur_tag = "R5 narrow";
      send_bits(64'h1, 2);
      send_bits(64'hF6F6F6282828, 48);
      cur_tag = "R6 narrow";
      send_bits(64'hD, 4);
      drain();

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule